// File: doc/BRIEF.md
# Two-Wire Serial Controller Register Bank

This block is the software-visible register bank of a two-wire serial controller. A simple synchronous bus slave port reaches it: each cycle the port may present a byte address, write data, a write strobe, a read strobe and an access size. One clock edge later it returns registered read data and an error flag. The bank holds the configuration for the serial engine: clock divider, global control, slave and master control and address, interrupt mask and FIFO control. It presents them on dedicated outputs. It also keeps the status words that the engine reports.

Hardware-side inputs feed the status. Five sticky master error flags and sixteen sticky interrupt flags are set by one-cycle event pulses and are cleared by software writing ones. Slave status, FIFO status and the upper master status flags are sampled from the engine every cycle and cannot be written. A single-entry transmit holding register is loaded through a narrow port or a wide port. A single-entry receive holding register is loaded by the engine and read through either receive port. An interrupt line is raised whenever an unmasked interrupt flag is pending.

Top module: `twi_csr_top`

## Requirements
- R1: After reset every register, the transmit and receive holding registers, the interrupt line and the read data are zero.
- R2: Words 0x00, 0x04, 0x08, 0x10, 0x14, 0x1C, 0x24 and 0x28 (clock divider, control, slave control, slave address, master control, master address, interrupt mask, FIFO control) read back the last value written and drive their configuration outputs.
- R3: An access whose size code is not 1 (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) is rejected. The flag bus_err is raised one cycle later and bus_err_size is set to 1, also for unmapped addresses, and the access changes nothing.
- R4: A correctly sized access to an unmapped or misaligned byte address (the gap 0x30 to 0x7C, anything above 0x8C, any address with bits 1:0 non-zero) sets bus_err with bus_err_size at 0, and changes no register.
- R5: A write to interrupt status (0x20) clears each of its 16 bits written as one. An event pulse on ev_int_set bit n sets bit n.
- R6: Master status (0x18) holds five sticky error flags in bits 4:0, set by ev_mst_err pulses and cleared by writing ones there. Bits 15:5 show hw_mst_flags as sampled one cycle earlier and are not affected by writes.
- R7: When a set event and a write-one clear hit the same sticky bit in one cycle, the bit ends up set.
- R8: Writes to slave status (0x0C), FIFO status (0x2C) and both receive ports (0x88, 0x8C) raise no error and change nothing. The two status words read hw_slv_flags and hw_fifo_flags sampled one cycle earlier.
- R9: A write to the narrow transmit port (0x80) loads tx_hold with the low 8 bits zero-extended. A write to the wide transmit port (0x84) loads all 16 bits.
- R10: Reads of 0x80 and 0x84 always return zero. Reads of 0x88 and 0x8C return the receive holding register, which is loaded from rx_data when rx_load is high.
- R11: irq is high exactly while the bitwise AND of interrupt status and interrupt mask is non-zero, and it changes in the same cycle as those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_size | input | 2 | Access size code (0 = 8, 1 = 16, 2 = 32 bits) |
| bus_rdata | output | 16 | Registered read data, valid the cycle after a read |
| bus_err | output | 1 | Registered access error |
| bus_err_size | output | 1 | Error cause: 1 size, 0 address |
| ev_int_set | input | 16 | Interrupt flag set pulses |
| ev_mst_err | input | 5 | Master error flag set pulses |
| hw_mst_flags | input | 11 | Live master status flags for bits 15:5 |
| hw_slv_flags | input | 16 | Live slave status |
| hw_fifo_flags | input | 16 | Live FIFO status |
| rx_load | input | 1 | Load receive holding register |
| rx_data | input | 16 | Receive data from the engine |
| tx_hold | output | 16 | Transmit holding register |
| cfg_clkdiv | output | 16 | Clock divider setting |
| cfg_ctrl | output | 16 | Global control |
| cfg_slv_ctl | output | 16 | Slave control |
| cfg_slv_addr | output | 16 | Slave address |
| cfg_mst_ctl | output | 16 | Master control |
| cfg_mst_addr | output | 16 | Master address |
| cfg_fifo_ctl | output | 16 | FIFO control |
| irq | output | 1 | Interrupt request |

## Verification
A read or an error presented at a clock edge shows on bus_rdata, bus_err and bus_err_size right after that edge. The effect of a write is visible to a read issued at the very next edge, and at the same moment on tx_hold, the configuration outputs and irq. An event pulse or a live status input lands in its register at the edge where it is presented. The bench drives every stimulus half a cycle before an edge. A monitor pops the expected response for each access at the falling edge after that access's edge. Direct output checks sample at falling edges after the write that affects them.

// File: rtl/twi_csr_pkg.sv
package twi_csr_pkg;
  localparam int CSR_DATA_W = 16;
  localparam int CSR_ADDR_W = 8;
  localparam int MERR_W     = 5;
  localparam int NUM_PLAIN  = 8;
  localparam int TX_NARROW_W = 8;

  // word index = byte address / 4
  localparam int IDX_CLKDIV  = 0;
  localparam int IDX_CTRL    = 1;
  localparam int IDX_SCTL    = 2;
  localparam int IDX_SSTAT   = 3;
  localparam int IDX_SADDR   = 4;
  localparam int IDX_MCTL    = 5;
  localparam int IDX_MSTAT   = 6;
  localparam int IDX_MADDR   = 7;
  localparam int IDX_ISTAT   = 8;
  localparam int IDX_IMASK   = 9;
  localparam int IDX_FCTL    = 10;
  localparam int IDX_FSTAT   = 11;
  localparam int IDX_TX8     = 32;
  localparam int IDX_TX16    = 33;
  localparam int IDX_RX8     = 34;
  localparam int IDX_RX16    = 35;

  localparam logic [1:0] SIZE_HALF = 2'd1;

  // slots inside the plain read/write bank
  localparam int SLOT_CLKDIV = 0;
  localparam int SLOT_CTRL   = 1;
  localparam int SLOT_SCTL   = 2;
  localparam int SLOT_SADDR  = 3;
  localparam int SLOT_MCTL   = 4;
  localparam int SLOT_MADDR  = 5;
  localparam int SLOT_IMASK  = 6;
  localparam int SLOT_FCTL   = 7;

  typedef enum logic [2:0] {
    K_PLAIN, K_ISTAT, K_MSTAT, K_RO, K_TX8, K_TX16, K_RX, K_NONE
  } acc_kind_t;

  function automatic logic [2:0] plain_slot(input int unsigned w);
    case (w)
      IDX_CLKDIV: plain_slot = 3'(SLOT_CLKDIV);
      IDX_CTRL:   plain_slot = 3'(SLOT_CTRL);
      IDX_SCTL:   plain_slot = 3'(SLOT_SCTL);
      IDX_SADDR:  plain_slot = 3'(SLOT_SADDR);
      IDX_MCTL:   plain_slot = 3'(SLOT_MCTL);
      IDX_MADDR:  plain_slot = 3'(SLOT_MADDR);
      IDX_IMASK:  plain_slot = 3'(SLOT_IMASK);
      default:    plain_slot = 3'(SLOT_FCTL);
    endcase
  endfunction
endpackage

// File: rtl/twi_csr_decode.sv
module twi_csr_decode
  import twi_csr_pkg::*;
#(
  parameter int ADDR_W = CSR_ADDR_W,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              we,
  input  logic              re,
  output logic [WORD_W-1:0] word,
  output acc_kind_t         kind,
  output logic              ok,
  output logic              unmapped,
  output logic              err,
  output logic              err_size
);
  logic        active;
  logic        size_bad;
  int unsigned wi;

  assign word = addr[ADDR_W-1:2];

  always_comb begin
    wi = 32'(word);
    kind = K_NONE;
    if (addr[1:0] == 2'b00) begin
      case (wi)
        IDX_CLKDIV, IDX_CTRL, IDX_SCTL, IDX_SADDR,
        IDX_MCTL, IDX_MADDR, IDX_IMASK, IDX_FCTL: kind = K_PLAIN;
        IDX_SSTAT, IDX_FSTAT:                     kind = K_RO;
        IDX_MSTAT:                                kind = K_MSTAT;
        IDX_ISTAT:                                kind = K_ISTAT;
        IDX_TX8:                                  kind = K_TX8;
        IDX_TX16:                                 kind = K_TX16;
        IDX_RX8, IDX_RX16:                        kind = K_RX;
        default:                                  kind = K_NONE;
      endcase
    end
  end

  assign active   = we | re;
  assign size_bad = (size != SIZE_HALF);
  assign unmapped = active & (kind == K_NONE);
  // size check outranks the address check
  assign err_size = active & size_bad;
  assign err      = err_size | unmapped;
  assign ok       = active & ~err;
endmodule

// File: rtl/twi_plain_bank.sv
module twi_plain_bank #(
  parameter int DW = 16,
  parameter int N  = 8,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [N*DW-1:0] q_flat,
  output logic [N*DW-1:0] qn_flat
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [DW-1:0] r;
    logic [DW-1:0] n;
    assign n = (wr_en && wr_sel == SW'(g)) ? wr_data : r;
    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else     r <= n;
    end
    assign q_flat[g*DW +: DW]  = r;
    assign qn_flat[g*DW +: DW] = n;
  end
endmodule

// File: rtl/twi_w1c_reg.sv
module twi_w1c_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] CLR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_en,
  input  logic [W-1:0] clr_data,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (CLR_MASK[b]) begin : g_clr
      // set wins over clear
      assign q_next[b] = set_bits[b] | (q[b] & ~(clr_en & clr_data[b]));
    end else begin : g_keep
      assign q_next[b] = set_bits[b] | q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end
endmodule

// File: rtl/twi_csr_top.sv
module twi_csr_top
  import twi_csr_pkg::*;
#(
  parameter int DATA_W = CSR_DATA_W,
  parameter int ADDR_W = CSR_ADDR_W,
  parameter int MERR_N = MERR_W,
  localparam int WORD_W = ADDR_W - 2,
  localparam int HI_W   = DATA_W - MERR_N,
  localparam int SLOT_W = $clog2(NUM_PLAIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              bus_err_size,
  input  logic [DATA_W-1:0] ev_int_set,
  input  logic [MERR_N-1:0] ev_mst_err,
  input  logic [HI_W-1:0]   hw_mst_flags,
  input  logic [DATA_W-1:0] hw_slv_flags,
  input  logic [DATA_W-1:0] hw_fifo_flags,
  input  logic              rx_load,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] tx_hold,
  output logic [DATA_W-1:0] cfg_clkdiv,
  output logic [DATA_W-1:0] cfg_ctrl,
  output logic [DATA_W-1:0] cfg_slv_ctl,
  output logic [DATA_W-1:0] cfg_slv_addr,
  output logic [DATA_W-1:0] cfg_mst_ctl,
  output logic [DATA_W-1:0] cfg_mst_addr,
  output logic [DATA_W-1:0] cfg_fifo_ctl,
  output logic              irq
);
  logic [WORD_W-1:0] dec_word;
  acc_kind_t         dec_kind;
  logic              dec_ok;
  logic              dec_unmapped;
  logic              dec_err;
  logic              dec_err_size;
  logic              wr_ok;
  logic              rd_ok;
  int unsigned       word_i;
  logic [SLOT_W-1:0] slot;

  twi_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .size     (bus_size),
    .we       (bus_we),
    .re       (bus_re),
    .word     (dec_word),
    .kind     (dec_kind),
    .ok       (dec_ok),
    .unmapped (dec_unmapped),
    .err      (dec_err),
    .err_size (dec_err_size)
  );

  assign wr_ok  = bus_we & dec_ok;
  assign rd_ok  = bus_re & dec_ok;
  assign word_i = 32'(dec_word);
  assign slot   = SLOT_W'(plain_slot(word_i));

  // plain read/write registers
  logic [NUM_PLAIN*DATA_W-1:0] plain_q;
  logic [NUM_PLAIN*DATA_W-1:0] plain_qn;

  twi_plain_bank #(.DW(DATA_W), .N(NUM_PLAIN)) u_plain (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ok && dec_kind == K_PLAIN),
    .wr_sel  (slot),
    .wr_data (bus_wdata),
    .q_flat  (plain_q),
    .qn_flat (plain_qn)
  );

  logic [DATA_W-1:0] imask;
  logic [DATA_W-1:0] imask_n;
  assign imask   = plain_q[SLOT_IMASK*DATA_W +: DATA_W];
  assign imask_n = plain_qn[SLOT_IMASK*DATA_W +: DATA_W];

  assign cfg_clkdiv   = plain_q[SLOT_CLKDIV*DATA_W +: DATA_W];
  assign cfg_ctrl     = plain_q[SLOT_CTRL*DATA_W +: DATA_W];
  assign cfg_slv_ctl  = plain_q[SLOT_SCTL*DATA_W +: DATA_W];
  assign cfg_slv_addr = plain_q[SLOT_SADDR*DATA_W +: DATA_W];
  assign cfg_mst_ctl  = plain_q[SLOT_MCTL*DATA_W +: DATA_W];
  assign cfg_mst_addr = plain_q[SLOT_MADDR*DATA_W +: DATA_W];
  assign cfg_fifo_ctl = plain_q[SLOT_FCTL*DATA_W +: DATA_W];

  // sticky interrupt flags, every bit write-one-to-clear
  logic [DATA_W-1:0] istat_q;
  logic [DATA_W-1:0] istat_n;

  twi_w1c_reg #(.W(DATA_W), .CLR_MASK('1)) u_istat (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (wr_ok && dec_kind == K_ISTAT),
    .clr_data (bus_wdata),
    .set_bits (ev_int_set),
    .q        (istat_q),
    .q_next   (istat_n)
  );

  // sticky master error flags
  logic [MERR_N-1:0] mst_err_q;
  logic [MERR_N-1:0] mst_err_n;

  twi_w1c_reg #(.W(MERR_N), .CLR_MASK('1)) u_mst (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (wr_ok && dec_kind == K_MSTAT),
    .clr_data (bus_wdata[MERR_N-1:0]),
    .set_bits (ev_mst_err),
    .q        (mst_err_q),
    .q_next   (mst_err_n)
  );

  // live status sampling and data holding registers
  logic [HI_W-1:0]   mst_hi_q;
  logic [DATA_W-1:0] slv_stat_q;
  logic [DATA_W-1:0] fifo_stat_q;
  logic [DATA_W-1:0] rx_hold_q;
  logic [DATA_W-1:0] tx_hold_q;
  logic [DATA_W-1:0] tx_wval;

  assign tx_wval = (dec_kind == K_TX8)
                 ? {{(DATA_W-TX_NARROW_W){1'b0}}, bus_wdata[TX_NARROW_W-1:0]}
                 : bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_hi_q    <= '0;
      slv_stat_q  <= '0;
      fifo_stat_q <= '0;
      rx_hold_q   <= '0;
      tx_hold_q   <= '0;
    end else begin
      mst_hi_q    <= hw_mst_flags;
      slv_stat_q  <= hw_slv_flags;
      fifo_stat_q <= hw_fifo_flags;
      if (rx_load) rx_hold_q <= rx_data;
      if (wr_ok && (dec_kind == K_TX8 || dec_kind == K_TX16))
        tx_hold_q <= tx_wval;
    end
  end

  assign tx_hold = tx_hold_q;

  // read path
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    case (dec_kind)
      K_PLAIN: rd_val = plain_q[slot*DATA_W +: DATA_W];
      K_ISTAT: rd_val = istat_q;
      K_MSTAT: rd_val = {mst_hi_q, mst_err_q};
      K_RO:    rd_val = (word_i == IDX_SSTAT) ? slv_stat_q : fifo_stat_q;
      K_RX:    rd_val = rx_hold_q;
      default: rd_val = '0;
    endcase
  end

  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              err_size_q;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      err_q      <= 1'b0;
      err_size_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      rdata_q    <= rd_ok ? rd_val : '0;
      err_q      <= dec_err;
      err_size_q <= dec_err_size;
      irq_q      <= |(istat_n & imask_n);
    end
  end

  assign bus_rdata    = rdata_q;
  assign bus_err      = err_q;
  assign bus_err_size = err_size_q;
  assign irq          = irq_q;
endmodule

// File: rtl/twi_csr_chk.sv
module twi_csr_chk
  import twi_csr_pkg::*;
#(
  parameter int DATA_W = CSR_DATA_W,
  parameter int MERR_N = MERR_W,
  parameter int PLAIN_W = NUM_PLAIN * CSR_DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic [1:0]        bus_size,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_err,
  input logic              bus_err_size,
  input acc_kind_t         dec_kind,
  input logic              dec_ok,
  input logic              dec_unmapped,
  input logic [PLAIN_W-1:0] plain_q,
  input logic [DATA_W-1:0] istat,
  input logic [DATA_W-1:0] imask,
  input logic [DATA_W-1:0] ev_int_set,
  input logic [MERR_N-1:0] mst_err,
  input logic [MERR_N-1:0] ev_mst_err,
  input logic [DATA_W-1:0] tx_hold,
  input logic              irq
);
  // R3
  size_err_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_we || bus_re) && bus_size != SIZE_HALF) |=> (bus_err && bus_err_size));

  // R4
  unmapped_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && dec_unmapped) |=> $stable(plain_q));

  // R5
  istat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && dec_ok && dec_kind == K_ISTAT && ev_int_set == '0)
      |=> ((istat & $past(bus_wdata)) == '0));

  // R7
  set_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_mst_err != '0) |=> ((mst_err & $past(ev_mst_err)) == $past(ev_mst_err)));

  // R9
  tx_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && dec_ok && dec_kind == K_TX8) |=> (tx_hold[DATA_W-1:TX_NARROW_W] == '0));

  // R11
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(istat & imask)));
endmodule

bind twi_csr_top twi_csr_chk #(
  .DATA_W (DATA_W),
  .MERR_N (MERR_N),
  .PLAIN_W(NUM_PLAIN*DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_we       (bus_we),
  .bus_re       (bus_re),
  .bus_size     (bus_size),
  .bus_wdata    (bus_wdata),
  .bus_err      (bus_err),
  .bus_err_size (bus_err_size),
  .dec_kind     (dec_kind),
  .dec_ok       (dec_ok),
  .dec_unmapped (dec_unmapped),
  .plain_q      (plain_q),
  .istat        (istat_q),
  .imask        (imask),
  .ev_int_set   (ev_int_set),
  .mst_err      (mst_err_q),
  .ev_mst_err   (ev_mst_err),
  .tx_hold      (tx_hold),
  .irq          (irq)
);

// File: tb/twi_csr_top_tb.sv
module twi_csr_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [1:0]    bus_size = 2'd1;
  logic [DW-1:0] bus_rdata;
  logic          bus_err;
  logic          bus_err_size;
  logic [DW-1:0] ev_int_set = '0;
  logic [4:0]    ev_mst_err = '0;
  logic [10:0]   hw_mst_flags = '0;
  logic [DW-1:0] hw_slv_flags = '0;
  logic [DW-1:0] hw_fifo_flags = '0;
  logic          rx_load = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [DW-1:0] tx_hold;
  logic [DW-1:0] cfg_clkdiv, cfg_ctrl, cfg_slv_ctl, cfg_slv_addr;
  logic [DW-1:0] cfg_mst_ctl, cfg_mst_addr, cfg_fifo_ctl;
  logic          irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_csr_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_size(bus_size),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_err_size(bus_err_size),
    .ev_int_set(ev_int_set), .ev_mst_err(ev_mst_err),
    .hw_mst_flags(hw_mst_flags), .hw_slv_flags(hw_slv_flags),
    .hw_fifo_flags(hw_fifo_flags), .rx_load(rx_load), .rx_data(rx_data),
    .tx_hold(tx_hold), .cfg_clkdiv(cfg_clkdiv), .cfg_ctrl(cfg_ctrl),
    .cfg_slv_ctl(cfg_slv_ctl), .cfg_slv_addr(cfg_slv_addr),
    .cfg_mst_ctl(cfg_mst_ctl), .cfg_mst_addr(cfg_mst_addr),
    .cfg_fifo_ctl(cfg_fifo_ctl), .irq(irq)
  );

  typedef struct {
    logic [DW-1:0] data;
    logic          chk_data;
    logic          err;
    logic          esize;
    string         req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic access(input logic we, input logic [7:0] a, input logic [DW-1:0] d,
                        input logic [1:0] sz, input logic [DW-1:0] exp_d,
                        input logic chk_d, input logic e, input logic es, input string req);
    exp_t it;
    it.data = exp_d; it.chk_data = chk_d; it.err = e; it.esize = es; it.req = req;
    exp_q.push_back(it);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = we; bus_re = ~we;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0; bus_size = 2'd1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d, input string req);
    access(1'b1, a, d, 2'd1, '0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic rd(input logic [7:0] a, input logic [DW-1:0] exp_d, input string req);
    access(1'b0, a, '0, 2'd1, exp_d, 1'b1, 1'b0, 1'b0, req);
  endtask

  // monitor / scoreboard
  always begin
    @(posedge clk);
    if (!rst && (bus_we || bus_re)) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard empty act=%h exp=none", bus_rdata);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        check({it.req, " err"}, DW'(bus_err), DW'(it.err));
        if (it.err) check({it.req, " err_size"}, DW'(bus_err_size), DW'(it.esize));
        if (it.chk_data) check({it.req, " rdata"}, bus_rdata, it.data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    check("R1 irq", DW'(irq), '0);
    check("R1 tx_hold", tx_hold, '0);
    check("R1 rdata", bus_rdata, '0);
    for (int i = 0; i < 12; i++) rd(8'(i*4), '0, "R1 reg");
    for (int i = 0; i < 4; i++) rd(8'(8'h80 + i*4), '0, "R1 port");

    // R2 plain read/write
    wr(8'h00, 16'hA5C3, "R2");
    wr(8'h04, 16'h1234, "R2");
    wr(8'h10, 16'h0055, "R2");
    wr(8'h1C, 16'h7E01, "R2");
    wr(8'h28, 16'hC0DE, "R2");
    rd(8'h00, 16'hA5C3, "R2 clkdiv");
    rd(8'h04, 16'h1234, "R2 ctrl");
    rd(8'h1C, 16'h7E01, "R2 maddr");
    check("R2 cfg_clkdiv", cfg_clkdiv, 16'hA5C3);
    check("R2 cfg_slv_addr", cfg_slv_addr, 16'h0055);
    check("R2 cfg_fifo_ctl", cfg_fifo_ctl, 16'hC0DE);

    // R3 size errors, size outranks address
    access(1'b1, 8'h00, 16'hFFFF, 2'd0, '0, 1'b0, 1'b1, 1'b1, "R3 byte write");
    access(1'b0, 8'h04, '0, 2'd2, '0, 1'b0, 1'b1, 1'b1, "R3 word read");
    access(1'b1, 8'h40, 16'h1111, 2'd0, '0, 1'b0, 1'b1, 1'b1, "R3 priority");
    rd(8'h00, 16'hA5C3, "R3 unchanged");

    // R4 unmapped / misaligned
    access(1'b1, 8'h40, 16'hFFFF, 2'd1, '0, 1'b0, 1'b1, 1'b0, "R4 gap");
    access(1'b1, 8'h02, 16'hFFFF, 2'd1, '0, 1'b0, 1'b1, 1'b0, "R4 misaligned");
    access(1'b1, 8'h90, 16'hFFFF, 2'd1, '0, 1'b0, 1'b1, 1'b0, "R4 above");
    access(1'b0, 8'h44, '0, 2'd1, '0, 1'b0, 1'b1, 1'b0, "R4 read gap");
    rd(8'h00, 16'hA5C3, "R4 clkdiv kept");
    rd(8'h04, 16'h1234, "R4 ctrl kept");

    // R8 read-only words
    hw_slv_flags = 16'h3C3C; hw_fifo_flags = 16'h0F0F;
    rx_load = 1'b1; rx_data = 16'h8421;
    @(negedge clk);
    rx_load = 1'b0; rx_data = 16'hFFFF;
    wr(8'h0C, 16'hFFFF, "R8 sstat write");
    wr(8'h2C, 16'h0000, "R8 fstat write");
    wr(8'h88, 16'h0000, "R8 rx8 write");
    wr(8'h8C, 16'h1111, "R8 rx16 write");
    rd(8'h0C, 16'h3C3C, "R8 sstat");
    rd(8'h2C, 16'h0F0F, "R8 fstat");
    rd(8'h88, 16'h8421, "R10 rx8");
    rd(8'h8C, 16'h8421, "R10 rx16");

    // R9 transmit ports
    wr(8'h80, 16'hBEEF, "R9 narrow");
    check("R9 narrow hold", tx_hold, 16'h00EF);
    wr(8'h84, 16'hBEEF, "R9 wide");
    check("R9 wide hold", tx_hold, 16'hBEEF);
    rd(8'h80, 16'h0000, "R10 tx8 read");
    rd(8'h84, 16'h0000, "R10 tx16 read");

    // R5 / R11 interrupt flags
    wr(8'h24, 16'h00F0, "R11 mask");
    check("R11 irq idle", DW'(irq), '0);
    ev_int_set = 16'h0F00;
    @(negedge clk);
    ev_int_set = '0;
    check("R11 masked off", DW'(irq), '0);
    ev_int_set = 16'h0030;
    @(negedge clk);
    ev_int_set = '0;
    check("R11 irq raised", DW'(irq), 16'h1);
    rd(8'h20, 16'h0F30, "R5 set");
    wr(8'h20, 16'h0010, "R5 partial clear");
    check("R11 still pending", DW'(irq), 16'h1);
    wr(8'h20, 16'h00F0, "R5 clear");
    check("R11 irq dropped", DW'(irq), '0);
    rd(8'h20, 16'h0F00, "R5 remaining");
    ev_int_set = 16'h0001;
    wr(8'h20, 16'hFFFF, "R7 istat");
    ev_int_set = '0;
    rd(8'h20, 16'h0001, "R7 istat set wins");

    // R6 master status
    hw_mst_flags = 11'h5A5;
    ev_mst_err = 5'h1F;
    @(negedge clk);
    ev_mst_err = '0;
    rd(8'h18, 16'hB4BF, "R6 set");
    wr(8'h18, 16'h000A, "R6 partial");
    rd(8'h18, 16'hB4B5, "R6 partial clear");
    wr(8'h18, 16'hFFFF, "R6 full");
    rd(8'h18, 16'hB4A0, "R6 high kept");
    ev_mst_err = 5'h04;
    wr(8'h18, 16'hFFFF, "R7 mstat");
    ev_mst_err = '0;
    rd(8'h18, 16'hB4A4, "R7 mstat set wins");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule